// File: doc/BRIEF.md
# Video Host Register and Interrupt Unit

This unit is the host-side register window of a tile and sprite video controller that also carries a PCM audio sample FIFO. A byte-wide synchronous bus writes registers on the clock edge and reads them combinationally from the current address. The window holds a control register, an interrupt-enable register, an interrupt status register and a shared scanline/compare-line register. The unit folds four interrupt sources into one active-high IRQ line: vertical sync, raster-line match, sprite collision and audio FIFO low-water.

The video pipeline supplies the live 9-bit scanline and the vertical-sync and sprite-collision strobes. The audio FIFO supplies its fill level. The unit drives the data-port select and the register-bank select for the neighbouring blocks. It also issues a one-cycle soft reset pulse when the host asks for one.

Top module: `vid_hostreg_irq`

## Requirements
- R1: After `rst_n` is released, the reads return these values: control reads 0x00, interrupt enable reads only the scanline bit 8 in bit 6, status reads 0x00 when the FIFO is at or above a quarter, and `irq` and `soft_rst` are 0.
- R2: A write to offset 0x05 stores bit 0 as `port_sel` and bit 1 as `bank_sel`. A read of 0x05 returns these two bits in positions 0 and 1, and 0 in bits 7..2.
- R3: Writing 0x05 with bit 7 set raises `soft_rst` for exactly the next cycle. At the end of that cycle, control, enables, compare line and pending flags are all zero. Bus writes made during that cycle are dropped, and bit 7 always reads 0.
- R4: Offset 0x06 holds the source enables in bits 3..0 (0 vsync, 1 raster line, 2 sprite collision, 3 FIFO low). On a read, bits 5..4 and bit 7 return 0 and bit 6 returns scanline bit 8. Writes to bit 6 have no effect.
- R5: A read of offset 0x08 returns scanline bits 7..0.
- R6: The 9-bit compare line is written at 0x08 (bits 7..0) and through bit 7 of 0x06 (bit 8). Status bit 1 latches one cycle after the scanline starts to equal the compare line. It does not latch again while the two stay equal.
- R7: A one-cycle `vsync_stb` sets status bit 0, and a one-cycle `sprcol_stb` sets status bit 2, both visible in the next cycle.
- R8: Offset 0x07 reads the status. Writing 1 to bit 0, 1 or 2 clears that pending flag. When a new event and a clear meet in the same cycle, the flag stays set.
- R9: Status bit 3 is live and is 1 exactly while `fifo_level` is below FIFO_DEPTH/4. A write to it has no effect.
- R10: `irq` is 1 exactly while some status bit i and enable bit i are both 1.
- R11: Offsets other than 0x05 to 0x08 read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| scanline | input | 9 | Live scanline from the video pipeline |
| vsync_stb | input | 1 | One-cycle vertical sync event |
| sprcol_stb | input | 1 | One-cycle sprite collision event |
| fifo_level | input | LVL_W | Audio FIFO fill level in samples |
| irq | output | 1 | Combined active-high interrupt |
| port_sel | output | 1 | Data-port select for the address registers |
| bank_sel | output | 1 | Register-bank select for offsets 0x09 to 0x0C |
| soft_rst | output | 1 | One-cycle soft reset pulse |

## Verification
The assertions take four things for granted. The event strobes are single-cycle pulses. `scanline` and `fifo_level` are held steady across each clock edge. A write to the status register is the only way a pending flag clears outside a reset. The stimulus changes every input only at the falling edge. It keeps the scanline inside a small band and writes compare values from the same band, so matches, held matches and bit-8 mismatches all occur often. Soft resets are drawn rarely, so the sequences between them stay long enough to exercise the pending flags.

// File: rtl/vhr_pkg.sv
package vhr_pkg;

  localparam int LINE_W = 9;
  localparam int NSRC   = 4;
  localparam int NLATCH = 3;

  // register offsets
  localparam int OFS_CTRL = 5;
  localparam int OFS_IEN  = 6;
  localparam int OFS_STAT = 7;
  localparam int OFS_LINE = 8;

  // control bits
  localparam int CB_PORT = 0;
  localparam int CB_BANK = 1;
  localparam int CB_SRST = 7;

  // source order, shared by enable and status registers
  localparam int SRC_VSYNC = 0;
  localparam int SRC_LINE  = 1;
  localparam int SRC_SPR   = 2;
  localparam int SRC_FIFO  = 3;

  // extra bits of the enable register
  localparam int IB_SCAN8 = 6;
  localparam int IB_LINE8 = 7;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [NSRC-1:0]   src_vec_t;

  typedef struct packed {
    logic we_ctrl;
    logic we_ien;
    logic we_stat;
    logic we_line;
  } wr_dec_t;

  // level below a quarter of depth, computed without division
  function automatic logic fifo_below_quarter(input logic [31:0] level,
                                              input logic [31:0] depth);
    return {level, 2'b00} < {2'b00, depth};
  endfunction

  function automatic logic any_enabled(input src_vec_t flags, input src_vec_t en);
    return |(flags & en);
  endfunction

  function automatic logic line_equal(input line_t a, input line_t b);
    return a == b;
  endfunction

endpackage

// File: rtl/vhr_decode.sv
module vhr_decode #(
  parameter int ADDR_W = 5
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              blocked,
  output vhr_pkg::wr_dec_t  dec
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(vhr_pkg::OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(vhr_pkg::OFS_IEN);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(vhr_pkg::OFS_STAT);
  localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(vhr_pkg::OFS_LINE);

  logic go;

  always_comb begin
    go          = wr && !blocked;
    dec.we_ctrl = go && (addr == A_CTRL);
    dec.we_ien  = go && (addr == A_IEN);
    dec.we_stat = go && (addr == A_STAT);
    dec.we_line = go && (addr == A_LINE);
  end
endmodule

// File: rtl/vhr_cfg_regs.sv
module vhr_cfg_regs (
  input  logic              clk,
  input  logic              rst_n,
  input  vhr_pkg::wr_dec_t  dec,
  input  logic [7:0]        wdata,
  output logic              port_sel,
  output logic              bank_sel,
  output vhr_pkg::src_vec_t ien,
  output vhr_pkg::line_t    irq_line,
  output logic              soft_rst
);
  import vhr_pkg::*;

  logic     port_q, bank_q, srst_q;
  src_vec_t ien_q;
  line_t    line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= 1'b0;
      bank_q <= 1'b0;
      srst_q <= 1'b0;
      ien_q  <= '0;
      line_q <= '0;
    end else if (srst_q) begin
      port_q <= 1'b0;
      bank_q <= 1'b0;
      srst_q <= 1'b0;
      ien_q  <= '0;
      line_q <= '0;
    end else begin
      if (dec.we_ctrl) begin
        port_q <= wdata[CB_PORT];
        bank_q <= wdata[CB_BANK];
        srst_q <= wdata[CB_SRST];
      end
      if (dec.we_ien) begin
        ien_q            <= wdata[NSRC-1:0];
        line_q[LINE_W-1] <= wdata[IB_LINE8];
      end
      if (dec.we_line) begin
        line_q[LINE_W-2:0] <= wdata;
      end
    end
  end

  assign port_sel = port_q;
  assign bank_sel = bank_q;
  assign ien      = ien_q;
  assign irq_line = line_q;
  assign soft_rst = srst_q;
endmodule

// File: rtl/vhr_irq_core.sv
module vhr_irq_core #(
  parameter int FIFO_DEPTH = 4096,
  parameter int LVL_W      = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  vhr_pkg::line_t        scanline,
  input  vhr_pkg::line_t        irq_line,
  input  logic                  vsync_stb,
  input  logic                  spr_stb,
  input  logic [LVL_W-1:0]      fifo_level,
  input  logic                  we_stat,
  input  logic [vhr_pkg::NLATCH-1:0] clr_bits,
  input  vhr_pkg::src_vec_t     ien,
  output vhr_pkg::src_vec_t     status,
  output logic                  irq,
  output logic                  line_match,
  output logic                  line_rise,
  output logic                  fifo_low
);
  import vhr_pkg::*;

  logic              match_q;
  logic [NLATCH-1:0] set_v;
  logic [NLATCH-1:0] pend;

  assign line_match = line_equal(scanline, irq_line);
  assign line_rise  = line_match && !match_q;
  assign fifo_low   = fifo_below_quarter(32'(fifo_level), 32'(FIFO_DEPTH));

  always_comb begin
    set_v            = '0;
    set_v[SRC_VSYNC] = vsync_stb;
    set_v[SRC_LINE]  = line_rise;
    set_v[SRC_SPR]   = spr_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   match_q <= 1'b0;
    else if (clr) match_q <= 1'b0;
    else          match_q <= line_match;
  end

  for (genvar i = 0; i < NLATCH; i++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        pend[i] <= 1'b0;
      else if (clr)                      pend[i] <= 1'b0;
      else if (set_v[i])                 pend[i] <= 1'b1;
      else if (we_stat && clr_bits[i])   pend[i] <= 1'b0;
    end
  end

  always_comb begin
    status                = '0;
    status[NLATCH-1:0]    = pend;
    status[SRC_FIFO]      = fifo_low;
  end

  assign irq = any_enabled(status, ien);
endmodule

// File: rtl/vhr_rdmux.sv
module vhr_rdmux #(
  parameter int ADDR_W = 5
) (
  input  logic              [ADDR_W-1:0] addr,
  input  logic              port_sel,
  input  logic              bank_sel,
  input  vhr_pkg::src_vec_t ien,
  input  vhr_pkg::src_vec_t status,
  input  vhr_pkg::line_t    scanline,
  output logic [7:0]        rdata
);
  import vhr_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(OFS_LINE);

  always_comb begin
    rdata = 8'h00;
    if (addr == A_CTRL) begin
      rdata[CB_PORT] = port_sel;
      rdata[CB_BANK] = bank_sel;
    end else if (addr == A_IEN) begin
      rdata[NSRC-1:0] = ien;
      rdata[IB_SCAN8] = scanline[LINE_W-1];
    end else if (addr == A_STAT) begin
      rdata[NSRC-1:0] = status;
    end else if (addr == A_LINE) begin
      rdata = scanline[LINE_W-2:0];
    end
  end
endmodule

// File: rtl/vid_hostreg_irq.sv
module vid_hostreg_irq #(
  parameter  int ADDR_W     = 5,
  parameter  int FIFO_DEPTH = 4096,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [8:0]        scanline,
  input  logic              vsync_stb,
  input  logic              sprcol_stb,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              irq,
  output logic              port_sel,
  output logic              bank_sel,
  output logic              soft_rst
);
  import vhr_pkg::*;

  wr_dec_t  dec;
  src_vec_t ien_bits;
  src_vec_t status;
  line_t    irq_line;
  logic     line_match;
  logic     line_rise;
  logic     fifo_low;

  vhr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr      (bus_wr),
    .addr    (bus_addr),
    .blocked (soft_rst),
    .dec     (dec)
  );

  vhr_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec      (dec),
    .wdata    (bus_wdata),
    .port_sel (port_sel),
    .bank_sel (bank_sel),
    .ien      (ien_bits),
    .irq_line (irq_line),
    .soft_rst (soft_rst)
  );

  vhr_irq_core #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (soft_rst),
    .scanline   (scanline),
    .irq_line   (irq_line),
    .vsync_stb  (vsync_stb),
    .spr_stb    (sprcol_stb),
    .fifo_level (fifo_level),
    .we_stat    (dec.we_stat),
    .clr_bits   (bus_wdata[NLATCH-1:0]),
    .ien        (ien_bits),
    .status     (status),
    .irq        (irq),
    .line_match (line_match),
    .line_rise  (line_rise),
    .fifo_low   (fifo_low)
  );

  vhr_rdmux #(.ADDR_W(ADDR_W)) u_rd (
    .addr     (bus_addr),
    .port_sel (port_sel),
    .bank_sel (bank_sel),
    .ien      (ien_bits),
    .status   (status),
    .scanline (scanline),
    .rdata    (bus_rdata)
  );
endmodule

// File: rtl/vhr_checker.sv
module vhr_checker #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              vsync_stb,
  input logic              sprcol_stb,
  input logic              line_rise,
  input logic [3:0]        ien_bits,
  input logic [3:0]        status,
  input logic              irq,
  input logic              port_sel,
  input logic              bank_sel,
  input logic              soft_rst
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(7);

  assert_srst_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);

  assert_srst_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!port_sel && !bank_sel && ien_bits == 4'h0 && status[2:0] == 3'b000));

  assert_srst_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL && bus_wdata[7] && !soft_rst) |=> soft_rst);

  assert_ctrl_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (bus_rdata[7:2] == 6'b0));

  assert_ien_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_IEN) |-> (bus_rdata[7] == 1'b0 && bus_rdata[5:4] == 2'b00));

  assert_line_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rise && !soft_rst) |=> status[1]);

  assert_vsync_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_stb && !soft_rst) |=> status[0]);

  assert_spr_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sprcol_stb && !soft_rst) |=> status[2]);

  assert_stat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT && bus_wdata[0] && !vsync_stb && !soft_rst) |=> !status[0]);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_bits == 4'h0) |-> !irq);
endmodule

bind vid_hostreg_irq vhr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .vsync_stb  (vsync_stb),
  .sprcol_stb (sprcol_stb),
  .line_rise  (line_rise),
  .ien_bits   (ien_bits),
  .status     (status),
  .irq        (irq),
  .port_sel   (port_sel),
  .bank_sel   (bank_sel),
  .soft_rst   (soft_rst)
);

// File: tb/sim_vid_hostreg_irq.sv
module sim_vid_hostreg_irq;
  localparam int ADDR_W = 5;
  localparam int DEPTH  = 4096;
  localparam int LVL_W  = 13;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_wdata, bus_rdata;
  logic [8:0]        scanline;
  logic              vsync_stb, sprcol_stb;
  logic [LVL_W-1:0]  fifo_level;
  logic              irq, port_sel, bank_sel, soft_rst;

  vid_hostreg_irq #(.ADDR_W(ADDR_W), .FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scanline(scanline),
    .vsync_stb(vsync_stb), .sprcol_stb(sprcol_stb), .fifo_level(fifo_level),
    .irq(irq), .port_sel(port_sel), .bank_sel(bank_sel), .soft_rst(soft_rst)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of the register state
  logic [1:0] m_ctrl;
  logic [3:0] m_ien;
  logic [8:0] m_line;
  logic [2:0] m_pend;
  logic       m_prev, m_srst;

  logic [8:0]       cur_scan;
  logic [LVL_W-1:0] cur_lvl;
  logic [7:0]       last_rd;
  logic             last_irq, last_srst;

  function automatic logic exp_low(input logic [LVL_W-1:0] lvl);
    return int'(lvl) < (DEPTH / 4);
  endfunction

  function automatic logic [3:0] exp_status();
    return {exp_low(cur_lvl), m_pend};
  endfunction

  function automatic logic [7:0] exp_read(input logic [ADDR_W-1:0] a);
    case (a)
      5'd5:    return {6'b0, m_ctrl};
      5'd6:    return {1'b0, cur_scan[8], 2'b00, m_ien};
      5'd7:    return {4'b0, exp_status()};
      5'd8:    return cur_scan[7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [ADDR_W-1:0] a);
    case (a)
      5'd5:    return "R2 control read";
      5'd6:    return "R4 enable read";
      5'd7:    return "R8 status read";
      5'd8:    return "R5 scanline read";
      default: return "R11 unmapped read";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic wr, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                       input logic vs, input logic sc);
    logic       match;
    logic [2:0] setv, clrv;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    scanline = cur_scan; fifo_level = cur_lvl;
    vsync_stb = vs; sprcol_stb = sc;
    #1;
    last_rd = bus_rdata; last_irq = irq; last_srst = soft_rst;
    chk(tag_of(a), 16'(bus_rdata), 16'(exp_read(a)));
    chk("R10 irq", 16'(irq), 16'(|(exp_status() & m_ien)));
    chk("R2 select outputs", 16'({port_sel, bank_sel}), 16'({m_ctrl[0], m_ctrl[1]}));
    chk("R3 soft_rst", 16'(soft_rst), 16'(m_srst));
    @(posedge clk);
    if (m_srst) begin
      m_ctrl = '0; m_ien = '0; m_line = '0; m_pend = '0; m_prev = 1'b0; m_srst = 1'b0;
    end else begin
      match  = (cur_scan == m_line);
      setv   = {sc, match & ~m_prev, vs};
      clrv   = (wr && a == 5'd7) ? d[2:0] : 3'b000;
      m_pend = (m_pend & ~clrv) | setv;
      m_prev = match;
      if (wr && a == 5'd5) begin m_ctrl = d[1:0]; m_srst = d[7]; end
      if (wr && a == 5'd6) begin m_ien = d[3:0]; m_line[8] = d[7]; end
      if (wr && a == 5'd8) m_line[7:0] = d;
    end
  endtask

  task automatic peek(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
    cycle(1'b0, a, 8'h00, 1'b0, 1'b0);
    chk(tag, 16'(last_rd), 16'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    vsync_stb = 0; sprcol_stb = 0;
    cur_scan = 9'h1FF; cur_lvl = 13'd2048;
    scanline = cur_scan; fifo_level = cur_lvl;
    m_ctrl = '0; m_ien = '0; m_line = '0; m_pend = '0; m_prev = 0; m_srst = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(5'd5, 8'h00, "R1 control after reset");
    peek(5'd6, 8'h40, "R1 enable after reset");
    peek(5'd7, 8'h00, "R1 status after reset");
    chk("R1 irq after reset", 16'(last_irq), 16'h0);
    peek(5'd8, 8'hFF, "R1 scanline after reset");

    // R2 control bits
    cycle(1'b1, 5'd5, 8'h7F, 0, 0);
    peek(5'd5, 8'h03, "R2 control readback");

    // R4 enable register, bit 6 follows scanline only
    cycle(1'b1, 5'd6, 8'h7F, 0, 0);
    peek(5'd6, 8'h4F, "R4 enable with scanline bit8 set");
    cur_scan = 9'h0FF;
    peek(5'd6, 8'h0F, "R4 bit6 write ignored");

    // R5 scanline low byte
    cur_scan = 9'h0A5;
    peek(5'd8, 8'hA5, "R5 scanline low byte");

    // R6 raster-line compare with bit 8
    cycle(1'b1, 5'd8, 8'h05, 0, 0);
    cycle(1'b1, 5'd6, 8'h82, 0, 0);
    cycle(1'b1, 5'd7, 8'h07, 0, 0);
    cur_scan = 9'h104;
    peek(5'd7, 8'h00, "R6 no match below line");
    cur_scan = 9'h105;
    cycle(1'b0, 5'd0, 8'h00, 0, 0);
    peek(5'd7, 8'h02, "R6 match latched");
    chk("R6 irq on line", 16'(last_irq), 16'h1);
    cycle(1'b1, 5'd7, 8'h02, 0, 0);
    peek(5'd7, 8'h00, "R6 held match not relatched");
    cur_scan = 9'h005;
    peek(5'd7, 8'h00, "R6 bit8 mismatch");
    cur_scan = 9'h105;
    cycle(1'b0, 5'd0, 8'h00, 0, 0);
    peek(5'd7, 8'h02, "R6 new match relatched");

    // R7 strobes
    cycle(1'b1, 5'd7, 8'h07, 0, 0);
    cycle(1'b0, 5'd0, 8'h00, 1, 0);
    peek(5'd7, 8'h01, "R7 vsync latched");
    cycle(1'b0, 5'd0, 8'h00, 0, 1);
    peek(5'd7, 8'h05, "R7 sprite collision latched");

    // R8 set beats clear
    cycle(1'b1, 5'd7, 8'h01, 1, 0);
    peek(5'd7, 8'h05, "R8 set wins over clear");
    cycle(1'b1, 5'd7, 8'h05, 0, 0);
    peek(5'd7, 8'h00, "R8 write-one clear");

    // R9 FIFO low threshold
    cur_lvl = 13'd1023;
    peek(5'd7, 8'h08, "R9 below quarter");
    cycle(1'b1, 5'd7, 8'h08, 0, 0);
    peek(5'd7, 8'h08, "R9 write to live bit ignored");
    cur_lvl = 13'd1024;
    peek(5'd7, 8'h00, "R9 at quarter");

    // R10 enable gating
    cycle(1'b1, 5'd6, 8'h08, 0, 0);
    cur_lvl = 13'd1;
    peek(5'd7, 8'h08, "R10 fifo status");
    chk("R10 irq with fifo enabled", 16'(last_irq), 16'h1);
    cycle(1'b1, 5'd6, 8'h00, 0, 0);
    peek(5'd7, 8'h08, "R10 status stays");
    chk("R10 irq masked", 16'(last_irq), 16'h0);

    // R11 unmapped offsets
    cycle(1'b1, 5'd31, 8'hFF, 0, 0);
    peek(5'd31, 8'h00, "R11 unmapped read");
    peek(5'd5, 8'h03, "R11 control untouched");
    peek(5'd0, 8'h00, "R11 offset 0 read");

    // R3 soft reset
    cur_lvl = 13'd2048;
    cycle(1'b1, 5'd6, 8'h0F, 0, 0);
    cycle(1'b1, 5'd5, 8'h81, 0, 0);
    cycle(1'b1, 5'd5, 8'h03, 0, 0);
    chk("R3 pulse present", 16'(last_srst), 16'h1);
    peek(5'd5, 8'h00, "R3 control cleared, write in pulse dropped");
    chk("R3 pulse one cycle", 16'(last_srst), 16'h0);
    peek(5'd6, 8'h40, "R3 enables cleared");

    // constrained random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] a;
      logic [7:0]        d;
      cur_scan = 9'((($urandom % 2) * 256) + ($urandom % 4));
      cur_lvl  = 13'($urandom % 2048);
      a = ($urandom % 8 == 0) ? ADDR_W'($urandom % 32) : ADDR_W'(5 + ($urandom % 4));
      d = 8'($urandom);
      if (a == 5'd5 && ($urandom % 32) != 0) d[7] = 1'b0;
      if (a == 5'd8) d = {6'b0, d[1:0]};
      cycle(1'($urandom % 2), a, d, ($urandom % 8) == 0, ($urandom % 8) == 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule